// File: doc/BRIEF.md
# Multi-Channel Pressure Acquisition Sequencer

This block paces the readout of up to four capacitive pressure sensors that share one external capacitance-to-digital converter. After reset it passes through a short start-up state and then waits for the converter's ready interrupt. Each accepted interrupt does four things in turn:

- it advances a 2-bit excitation select to the next sensor;
- it reads the conversion result over a mode-0 SPI transfer;
- it packs the result with the chip address and channel number into a 20-bit word;
- it presents that word to an external error-correction and checksum encoder.

Several chips share one radio medium, so the sequencer holds the encoded word back for a time slot set by its 2-bit chip address. Only after that slot does it fire a one-cycle transmit strobe. Readings repeat at most once per frame period. All slot and frame timing is counted in ticks of a tick-enable input, and a parameter scales the tick count per millisecond.

Top module: `sensor_acq_seq`

## Requirements
- R1: While reset is asserted, and on the first sample after release, `chan_sel` is 0, `spi_cs_n` is 1, `spi_sclk` is 0, and `enc_req` and `tx_start` are 0. A reset in the middle of a packet abandons the packet, and the next packet carries channel tag 0.
- R2: While `cdc_ready` is 0 the block stays idle. `spi_cs_n` stays 1 and `enc_req` stays 0.
- R3: The SPI read idles with `spi_sclk` low. `spi_cs_n` is low for the whole transfer. Exactly 16 rising clock edges occur while it is low, and `spi_miso` is sampled on each rising edge, most significant bit first. The lower 14 bits received are kept as the reading.
- R4: `pkg_word` bit 0 is addr[0] and bit 1 is addr[1]. Bits 15:2 hold reading bits 13:0, with bit 2 as reading bit 0. Bits 17:16 hold the channel tag, with bit 16 as tag bit 0. Bits 19:18 repeat the address, with bit 18 as addr[0].
- R5: The channel tag of a packet is the `chan_sel` value at the moment the ready interrupt is accepted. `chan_sel` then increments by one, and it wraps from 3 to 0.
- R6: `enc_req` stays high, and `pkg_word` stays stable, until `enc_done` is sampled high. No SPI transfer runs during that time.
- R7: With a tick on every cycle, `tx_start` rises exactly addr*SLOT_MS*TICKS_PER_MS + 2 cycles after the edge that samples `enc_done`. The slot is 0, 70, 140 or 210 ms for address 0 to 3.
- R8: The slot and frame timers advance only on cycles with `tick_en` high.
- R9: With `cdc_ready` held high and a tick on every cycle, successive `tx_start` pulses are exactly PERIOD_MS*TICKS_PER_MS cycles apart.
- R10: `tx_start` is a single-cycle pulse, and there is one pulse per accepted interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Time-base tick enable for the slot and frame timers |
| chip_addr | input | 2 | Chip address; selects the transmit slot |
| cdc_ready | input | 1 | Converter ready interrupt |
| spi_miso | input | 1 | SPI data from the converter |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | SPI chip select, active low |
| chan_sel | output | 2 | Excitation multiplexer select |
| pkg_word | output | 20 | Packed word for the encoder |
| enc_req | output | 1 | Packed word valid, waiting for the encoder |
| enc_done | input | 1 | Encoder has finished with the word |
| tx_start | output | 1 | One-cycle release strobe for transmission |

## Verification
The bench builds the block with TICKS_PER_MS = 3 and SCLK_HALF = 2, and it drives `tick_en` high on almost every cycle. This shortens the 70 ms slot to 210 cycles and the 250 ms frame to 750 cycles. At that scale, all four address slots, an exact frame spacing, channel wrap-around and a stalled-tick interval fit in a few thousand cycles. It also keeps the slot arithmetic exact, so latencies are checked to the cycle.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int SPI_FRAME_BITS = 16;
  localparam int DATA_BITS      = 14;
  localparam int CHAN_W         = 2;
  localparam int ADDR_W         = 2;
  localparam int WORD_BITS      = 2 * ADDR_W + DATA_BITS + CHAN_W;

  typedef enum logic [3:0] {
    ST_INIT,
    ST_IDLE,
    ST_NEWCH,
    ST_READ,
    ST_PACK,
    ST_ENCODE,
    ST_SLOT,
    ST_OUTPUT,
    ST_HOLD
  } seq_state_e;

  // Address at both ends so that the word fills whole 4-bit symbols.
  function automatic logic [WORD_BITS-1:0] pack_word(
    input logic [ADDR_W-1:0]    addr,
    input logic [CHAN_W-1:0]    chan,
    input logic [DATA_BITS-1:0] reading
  );
    return {addr, chan, reading, addr};
  endfunction
endpackage

// File: rtl/acq_rst_sync.sv
module acq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/acq_tick_timer.sv
module acq_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Saturates at the limit, so hit stays true once reached.
  assign cnt_en = clr | (tick_en & (cnt_q != limit));

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit = (cnt_q == limit);
endmodule

// File: rtl/acq_spi_rd.sv
module acq_spi_rd #(
  parameter int HALF_DIV   = 4,
  parameter int FRAME_BITS = 16,
  parameter int DATA_BITS  = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 miso,
  output logic                 sclk,
  output logic                 cs_n,
  output logic [DATA_BITS-1:0] data,
  output logic                 done
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_BITS + 1);

  logic                  busy_q, busy_d;
  logic                  sclk_q, sclk_d;
  logic                  done_q, done_d;
  logic [DIV_W-1:0]      div_q, div_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [FRAME_BITS-1:0] shift_q, shift_d;

  always_comb begin
    busy_d  = busy_q;
    sclk_d  = sclk_q;
    div_d   = div_q;
    bit_d   = bit_q;
    shift_d = shift_q;
    done_d  = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sclk_d = 1'b0;
        div_d  = '0;
        bit_d  = '0;
      end
    end else if (div_q == DIV_W'(HALF_DIV - 1)) begin
      div_d = '0;
      if (!sclk_q) begin
        // Rising edge: take the bit the converter set up on the last fall.
        sclk_d  = 1'b1;
        shift_d = {shift_q[FRAME_BITS-2:0], miso};
      end else begin
        sclk_d = 1'b0;
        bit_d  = bit_q + BIT_W'(1);
        if (bit_q == BIT_W'(FRAME_BITS - 1)) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
    end else begin
      div_d = div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
    end else begin
      busy_q  <= busy_d;
      sclk_q  <= sclk_d;
      done_q  <= done_d;
      div_q   <= div_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
    end
  end

  assign cs_n = ~busy_q;
  assign sclk = sclk_q;
  assign data = shift_q[DATA_BITS-1:0];
  assign done = done_q;
endmodule

// File: rtl/sensor_acq_seq.sv
module sensor_acq_seq
  import acq_pkg::*;
#(
  parameter int TICKS_PER_MS = 1000,
  parameter int SLOT_MS      = 70,
  parameter int PERIOD_MS    = 250,
  parameter int SCLK_HALF    = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic [ADDR_W-1:0]    chip_addr,
  input  logic                 cdc_ready,
  input  logic                 spi_miso,
  output logic                 spi_sclk,
  output logic                 spi_cs_n,
  output logic [CHAN_W-1:0]    chan_sel,
  output logic [WORD_BITS-1:0] pkg_word,
  output logic                 enc_req,
  input  logic                 enc_done,
  output logic                 tx_start
);
  localparam int SLOT_TICKS   = SLOT_MS * TICKS_PER_MS;
  localparam int PERIOD_TICKS = PERIOD_MS * TICKS_PER_MS;
  localparam int CNT_W        = $clog2(PERIOD_TICKS + 1);
  // The timer clears on the accept cycle and the return to idle costs one
  // more cycle, so hitting at PERIOD-2 gives an accept spacing of PERIOD.
  localparam logic [CNT_W-1:0] FRAME_LIM = CNT_W'(PERIOD_TICKS - 2);

  logic srst_n;

  seq_state_e state_q, state_d;
  logic [CHAN_W-1:0]    chan_q, tag_q;
  logic [WORD_BITS-1:0] word_q;
  logic                 chan_en, word_en;

  logic                 spi_done;
  logic [DATA_BITS-1:0] spi_data;
  logic                 frame_clr, frame_hit;
  logic                 slot_clr, slot_hit;
  logic [CNT_W-1:0]     slot_lim;

  acq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  acq_spi_rd #(
    .HALF_DIV   (SCLK_HALF),
    .FRAME_BITS (SPI_FRAME_BITS),
    .DATA_BITS  (DATA_BITS)
  ) u_spi (
    .clk   (clk),
    .rst_n (srst_n),
    .start (state_q == ST_NEWCH),
    .miso  (spi_miso),
    .sclk  (spi_sclk),
    .cs_n  (spi_cs_n),
    .data  (spi_data),
    .done  (spi_done)
  );

  always_comb slot_lim = CNT_W'(int'(chip_addr) * SLOT_TICKS);

  assign frame_clr = (state_q == ST_IDLE) && cdc_ready;
  assign slot_clr  = (state_q != ST_SLOT);

  acq_tick_timer #(.CNT_W(CNT_W)) u_frame (
    .clk     (clk),
    .rst_n   (srst_n),
    .clr     (frame_clr),
    .tick_en (tick_en),
    .limit   (FRAME_LIM),
    .hit     (frame_hit)
  );

  acq_tick_timer #(.CNT_W(CNT_W)) u_slot (
    .clk     (clk),
    .rst_n   (srst_n),
    .clr     (slot_clr),
    .tick_en (tick_en),
    .limit   (slot_lim),
    .hit     (slot_hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT:   state_d = ST_IDLE;
      ST_IDLE:   if (cdc_ready) state_d = ST_NEWCH;
      ST_NEWCH:  state_d = ST_READ;
      ST_READ:   if (spi_done) state_d = ST_PACK;
      ST_PACK:   state_d = ST_ENCODE;
      ST_ENCODE: if (enc_done) state_d = ST_SLOT;
      ST_SLOT:   if (slot_hit) state_d = ST_OUTPUT;
      ST_OUTPUT: state_d = ST_HOLD;
      ST_HOLD:   if (frame_hit) state_d = ST_IDLE;
      default:   state_d = ST_INIT;
    endcase
  end

  assign chan_en = (state_q == ST_NEWCH);
  assign word_en = (state_q == ST_PACK);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= ST_INIT;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      chan_q <= '0;
      tag_q  <= '0;
    end else if (chan_en) begin
      tag_q  <= chan_q;
      chan_q <= chan_q + CHAN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      word_q <= '0;
    else if (word_en) word_q <= pack_word(chip_addr, tag_q, spi_data);
  end

  assign chan_sel = chan_q;
  assign pkg_word = word_q;
  assign enc_req  = (state_q == ST_ENCODE);
  assign tx_start = (state_q == ST_OUTPUT);
endmodule

// File: rtl/acq_seq_checker.sv
module acq_seq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        spi_sclk,
  input logic        spi_cs_n,
  input logic [1:0]  chan_sel,
  input logic [19:0] pkg_word,
  input logic        enc_req,
  input logic        enc_done,
  input logic        tx_start
);
  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> !spi_cs_n); // R3

  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_req && !enc_done) |=> (enc_req && $stable(pkg_word))); // R6

  AST_NO_SPI_IN_ENC: assert property (@(posedge clk) disable iff (!rst_n)
    enc_req |-> spi_cs_n); // R6

  AST_CHAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_sel) |-> (chan_sel == $past(chan_sel) + 2'd1)); // R5

  AST_TX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start); // R10
endmodule

bind sensor_acq_seq acq_seq_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .spi_sclk (spi_sclk),
  .spi_cs_n (spi_cs_n),
  .chan_sel (chan_sel),
  .pkg_word (pkg_word),
  .enc_req  (enc_req),
  .enc_done (enc_done),
  .tx_start (tx_start)
);

// File: tb/tb_sensor_acq_seq.sv
`timescale 1ns/1ps
module tb_sensor_acq_seq;
  localparam int TPMS   = 3;
  localparam int SLOT_T = 70 * TPMS;
  localparam int PER_T  = 250 * TPMS;
  localparam int NVEC   = 6;
  // Each entry: {chip address, 16-bit SPI frame}
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd0, 16'hFFFF}, {2'd1, 16'h0001}, {2'd2, 16'hA5C3},
    {2'd3, 16'h2AAA}, {2'd0, 16'hC000}, {2'd1, 16'h1234}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic [1:0]  chip_addr = 2'd0;
  logic        cdc_ready = 1'b0;
  logic        spi_miso = 1'b0;
  logic        enc_done = 1'b0;
  logic        spi_sclk, spi_cs_n, enc_req, tx_start;
  logic [1:0]  chan_sel;
  logic [19:0] pkg_word;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int exp_tag = 0;
  int rise_cnt = 0;
  int slv_idx = 0;
  logic [15:0] slv_data = 16'h0;

  sensor_acq_seq #(.TICKS_PER_MS(TPMS), .SCLK_HALF(2)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .chip_addr(chip_addr),
    .cdc_ready(cdc_ready), .spi_miso(spi_miso), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .chan_sel(chan_sel), .pkg_word(pkg_word),
    .enc_req(enc_req), .enc_done(enc_done), .tx_start(tx_start)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Mode-0 converter model: shifts out MSB first, changes data on falling edges.
  always @(negedge spi_cs_n) begin
    slv_idx  = 15;
    spi_miso = slv_data[15];
  end
  always @(negedge spi_sclk) begin
    if (!spi_cs_n) begin
      slv_idx = slv_idx - 1;
      if (slv_idx >= 0) spi_miso = slv_data[slv_idx];
    end
  end
  always @(posedge spi_sclk) if (!spi_cs_n) rise_cnt = rise_cnt + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_word(input logic [1:0] a, input logic [1:0] c,
                                           input logic [15:0] frame);
    logic [19:0] w;
    w[0] = a[0];
    w[1] = a[1];
    for (int i = 0; i < 14; i++) w[2 + i] = frame[i];
    w[16] = c[0];
    w[17] = c[1];
    w[18] = a[0];
    w[19] = a[1];
    return w;
  endfunction

  task automatic wait_enc();
    int n = 0;
    while (!enc_req && n < 5000) begin @(negedge clk); n++; end
    chk(enc_req, "R2", "enc_req never rose", 32'(enc_req), 1);
  endtask

  task automatic wait_tx(output int n);
    n = 1;
    while (!tx_start && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic run_pkt(input logic [1:0] a, input logic [15:0] frame);
    int n;
    logic [19:0] w0;
    @(negedge clk);
    chip_addr = a;
    slv_data  = frame;
    rise_cnt  = 0;
    cdc_ready = 1'b1;
    wait_enc();
    cdc_ready = 1'b0;
    chk(rise_cnt == 16, "R3", "sclk rising edges", 32'(rise_cnt), 16);
    chk(pkg_word == exp_word(a, 2'(exp_tag), frame), "R4", "packed word",
        32'(pkg_word), 32'(exp_word(a, 2'(exp_tag), frame)));
    chk(chan_sel == 2'(exp_tag + 1), "R5", "chan_sel after accept",
        32'(chan_sel), 32'(2'(exp_tag + 1)));
    w0 = pkg_word;
    repeat (3) @(negedge clk);
    chk(enc_req && pkg_word == w0 && spi_cs_n, "R6", "word held while waiting",
        32'(pkg_word), 32'(w0));
    enc_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    enc_done = 1'b0;
    wait_tx(n);
    chk(n == int'(a) * SLOT_T + 2, "R7", "slot latency", 32'(n), 32'(int'(a) * SLOT_T + 2));
    @(negedge clk);
    chk(!tx_start, "R10", "tx_start width", 32'(tx_start), 0);
    exp_tag = (exp_tag + 1) % 4;
    repeat (PER_T + 20) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int n;
    int t0;
    int t1;
    repeat (3) @(negedge clk);
    chk(chan_sel == 0 && spi_cs_n && !spi_sclk && !enc_req && !tx_start, "R1",
        "outputs in reset", {27'd0, chan_sel, spi_cs_n, spi_sclk, enc_req}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(chan_sel == 0 && spi_cs_n && !spi_sclk && !enc_req && !tx_start, "R1",
        "outputs after release", {27'd0, chan_sel, spi_cs_n, spi_sclk, enc_req}, 32'h4);

    // R2: no activity without the ready interrupt
    n = 0;
    repeat (200) begin
      @(negedge clk);
      if (!spi_cs_n || enc_req || tx_start) n++;
    end
    chk(n == 0, "R2", "activity while ready low", 32'(n), 0);
    chk(chan_sel == 0, "R2", "chan_sel while idle", 32'(chan_sel), 0);

    for (int v = 0; v < NVEC; v++) run_pkt(VEC[v][17:16], VEC[v][15:0]);

    // R8: slot timer frozen without ticks
    @(negedge clk);
    chip_addr = 2'd1;
    slv_data  = 16'h5A5A;
    cdc_ready = 1'b1;
    wait_enc();
    cdc_ready = 1'b0;
    enc_done = 1'b1;
    tick_en  = 1'b0;
    @(posedge clk);
    @(negedge clk);
    enc_done = 1'b0;
    n = 0;
    repeat (300) begin
      @(negedge clk);
      if (tx_start) n++;
    end
    chk(n == 0, "R8", "tx_start without ticks", 32'(n), 0);
    tick_en = 1'b1;
    @(negedge clk);
    wait_tx(n);
    chk(n == SLOT_T + 1, "R8", "latency after ticks resume", 32'(n), 32'(SLOT_T + 1));
    exp_tag = (exp_tag + 1) % 4;
    repeat (PER_T + 20) @(negedge clk);

    // R9: packet spacing with ready held high
    @(negedge clk);
    chip_addr = 2'd0;
    slv_data  = 16'h0F0F;
    cdc_ready = 1'b1;
    t0 = 0;
    t1 = 0;
    for (int k = 0; k < 2; k++) begin
      wait_enc();
      chk(pkg_word[17:16] == 2'(exp_tag), "R5", "channel tag wrap",
          32'(pkg_word[17:16]), 32'(exp_tag));
      enc_done = 1'b1;
      @(posedge clk);
      @(negedge clk);
      enc_done = 1'b0;
      wait_tx(n);
      if (k == 0) t0 = cyc; else t1 = cyc;
      exp_tag = (exp_tag + 1) % 4;
      @(negedge clk);
    end
    cdc_ready = 1'b0;
    chk(t1 - t0 == PER_T, "R9", "tx_start spacing", 32'(t1 - t0), 32'(PER_T));
    repeat (PER_T + 20) @(negedge clk);

    // R1: reset in the middle of a packet
    @(negedge clk);
    cdc_ready = 1'b1;
    wait_enc();
    cdc_ready = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(chan_sel == 0 && !enc_req && spi_cs_n && !tx_start, "R1", "mid-packet reset",
        {28'd0, chan_sel, enc_req, spi_cs_n}, 32'h1);
    rst_n = 1'b1;
    exp_tag = 0;
    repeat (5) @(negedge clk);
    run_pkt(2'd2, 16'h3C3C);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule